// File: doc/BRIEF.md
# Supply Sequencing Control Register

This block keeps the turn-on request bits for four hot-swapped rails: +12V, 5V, 3.3V and −12V. The power-on input, the board-select input and a simple host write port set and clear those bits. The bits drive four rail enable requests toward the gate-drive and timer logic. A configuration input picks one of two start modes. In simultaneous mode every requested rail ramps inside one timing cycle. In sequenced mode the rails come up one after another, in a fixed order. The end-of-ramp pulse from the ramp timer sets the request bit of the next rail.

The block also returns a status byte. Its low nibble shows the request bits. Its high nibble shows which rails are actually on: a rail counts as on when its enable request is high and the timer reports that rail as armed. Faults and board events clear request bits according to the active mode. In sequenced mode, a retry after a fault therefore starts again from the first rail.

Top module: `supply_seq_reg`

## Requirements
- R1: After reset all four request bits are 0, so `rail_en` = 0000 and `status` = 0x00.
- R2: With `seq_en` = 0, a rising edge on `pwr_on` sets all four request bits in the next cycle. Bit order is 0 = +12V, 1 = 5V, 2 = 3.3V, 3 = −12V. `status[3:0]` shows the request bits.
- R3: With `seq_en` = 1, a rising edge on `pwr_on` sets only bit 0. Each later `ramp_done` pulse sets the bit of the rail after the one whose ramp just ended, in the order 0, 1, 2, 3.
- R4: In sequenced mode the chain ends, and sets nothing, when the next rail's bit is already 1 or when the rail that just ramped is bit 3. Later `ramp_done` pulses then have no effect.
- R5: In sequenced mode, a host write that newly sets request bits starts the chain at the lowest newly set rail.
- R6: A host write (`host_we`, new request value on `host_wdata[3:0]`) cannot set any bit while `ramp_busy` = 1. Bits the write clears are cleared in every case.
- R7: With `seq_en` = 1, `fault_off` clears bits 3:1, keeps bit 0 and stops any running chain. With `seq_en` = 0, `fault_off` leaves the request bits unchanged.
- R8: With `seq_en` = 1, a rising edge on `board_sel` (board selected) clears bits 3:1 and keeps bit 0.
- R9: A falling edge on `pwr_on`, or a falling edge on `board_sel`, clears all four request bits.
- R10: When `neg_off` = 1, `rail_en[3]` follows request bit 0 instead of bit 3.
- R11: `status[4+i]` is `rail_en[i]` AND `rail_armed[i]`. It is never 1 while that rail's enable is 0.
- R12: Sets that arrive in the same cycle (power-on edge, host write, chaining) combine by OR. Any clear arriving in that cycle wins over a set of the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_on | input | 1 | Power-on request input |
| board_sel | input | 1 | Board selected (high = selected) |
| seq_en | input | 1 | 1 = sequenced start, 0 = simultaneous |
| neg_off | input | 1 | −12V enable follows request bit 0 |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 4 | New request bits from the host |
| ramp_busy | input | 1 | Ramp timer is busy |
| ramp_done | input | 1 | One-cycle end-of-ramp pulse |
| fault_off | input | 1 | Fault shutdown strobe |
| rail_armed | input | 4 | Per-rail armed/on report from the timer |
| rail_en | output | 4 | Per-rail enable requests |
| status | output | 8 | {rails on, request bits} |

## Verification
The bench aims at the points where sequencing goes wrong. It checks that the chain stops at an already-set rail; a design that re-arms that rail would keep setting bits on every later `ramp_done`. It checks that a host-started chain begins at the written rail and not at +12V; a design that got this wrong would power rails outside the requested order. It checks that a sequenced-mode fault keeps bit 0; losing it would stop automatic retries. It also covers writes while the timer is busy, and same-cycle collisions of sets and clears, where a wrong priority would leave a faulted rail requested. Finally, a long stretch of random stimulus is compared against a behavioural model on every cycle.

// File: rtl/supply_seq_reg.sv
module supply_seq_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_on,
  input  logic       board_sel,
  input  logic       seq_en,
  input  logic       neg_off,
  input  logic       host_we,
  input  logic [3:0] host_wdata,
  input  logic       ramp_busy,
  input  logic       ramp_done,
  input  logic       fault_off,
  input  logic [3:0] rail_armed,
  output logic [3:0] rail_en,
  output logic [7:0] status
);

  logic [3:0] req;
  logic       on_q, sel_q;
  logic       chain_act;
  logic [1:0] chain_ptr;

  logic on_rise, on_fall, sel_rise, sel_fall;
  assign on_rise  =  pwr_on & ~on_q;
  assign on_fall  = ~pwr_on &  on_q;
  assign sel_rise =  board_sel & ~sel_q;
  assign sel_fall = ~board_sel &  sel_q;

  logic kill_all, kill_upper;
  assign kill_all   = on_fall | sel_fall;
  assign kill_upper = seq_en & (fault_off | sel_rise);

  logic [3:0] host_set, host_clr;
  assign host_set = (host_we && !ramp_busy) ? (host_wdata & ~req) : 4'b0000;
  assign host_clr = host_we ? (req & ~host_wdata) : 4'b0000;

  logic [2:0] nxt_idx;
  logic       chain_step, chain_hit;
  assign nxt_idx    = {1'b0, chain_ptr} + 3'd1;
  assign chain_step = seq_en & chain_act & ramp_done;
  assign chain_hit  = chain_step & (chain_ptr != 2'd3) & ~req[nxt_idx[1:0]];

  logic [3:0] chain_set, pin_set, set_mask, clr_mask, start_mask;
  assign chain_set  = chain_hit ? (4'b0001 << nxt_idx[1:0]) : 4'b0000;
  assign pin_set    = on_rise ? (seq_en ? 4'b0001 : 4'b1111) : 4'b0000;
  assign set_mask   = pin_set | host_set | chain_set;
  assign clr_mask   = kill_all ? 4'b1111 : (host_clr | (kill_upper ? 4'b1110 : 4'b0000));
  assign start_mask = seq_en ? ((on_rise ? 4'b0001 : 4'b0000) | host_set) : 4'b0000;

  logic [1:0] start_idx;
  always_comb begin
    start_idx = 2'd0;
    for (int i = 3; i >= 0; i--)
      if (start_mask[i]) start_idx = 2'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req       <= 4'b0000;
      on_q      <= 1'b0;
      sel_q     <= 1'b0;
      chain_act <= 1'b0;
      chain_ptr <= 2'd0;
    end else begin
      on_q  <= pwr_on;
      sel_q <= board_sel;
      req   <= (req | set_mask) & ~clr_mask;
      if (kill_all || kill_upper) begin
        chain_act <= 1'b0;
      end else if (start_mask != 4'b0000) begin
        chain_act <= 1'b1;
        chain_ptr <= start_idx;
      end else if (chain_step) begin
        if (chain_hit) chain_ptr <= nxt_idx[1:0];
        else           chain_act <= 1'b0;
      end
    end
  end

  assign rail_en = {neg_off ? req[0] : req[3], req[2:0]};
  assign status  = {rail_en & rail_armed, req};

  assert_off_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (on_q && !pwr_on) |=> (rail_en == 4'b0000));

  assert_fault_keeps_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_en && fault_off) |=> (status[3:1] == 3'b000));

  assert_busy_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && ramp_busy && !on_rise && !chain_step) |=> ((status[3:0] & ~$past(status[3:0])) == 4'b0000));

  assert_select_trims_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_en && board_sel && !sel_q) |=> (status[3:1] == 3'b000));

  assert_seq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_en && !host_we && !ramp_done && !fault_off && !sel_rise && !sel_fall)
      |=> ($countones(status[3:0] & ~$past(status[3:0])) <= 1));

  assert_chain_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_act && !host_we && !on_rise) |=> ((status[3:0] & ~$past(status[3:0])) == 4'b0000));

endmodule

// File: tb/supply_seq_reg_tb.sv
`timescale 1ns/1ps
module supply_seq_reg_tb;
  logic clk = 0, rst_n = 0;
  logic pwr_on = 0, board_sel = 0, seq_en = 0, neg_off = 0;
  logic host_we = 0, ramp_busy = 0, ramp_done = 0, fault_off = 0;
  logic [3:0] host_wdata = 0, rail_armed = 0;
  logic [3:0] rail_en;
  logic [7:0] status;

  int total = 0, bad = 0;
  string phase = "R1";
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  supply_seq_reg u_dut (.clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .board_sel(board_sel),
    .seq_en(seq_en), .neg_off(neg_off), .host_we(host_we), .host_wdata(host_wdata),
    .ramp_busy(ramp_busy), .ramp_done(ramp_done), .fault_off(fault_off),
    .rail_armed(rail_armed), .rail_en(rail_en), .status(status));

  // behavioural reference
  bit m_req[4];
  bit m_onq, m_selq, m_act;
  int m_ptr;

  function automatic logic [3:0] m_bits();
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = m_req[i];
    return v;
  endfunction

  function automatic logic [7:0] m_status();
    logic [3:0] b, en;
    b = m_bits();
    en = b;
    if (neg_off) en[3] = b[0];
    return {en & rail_armed, b};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_req[i]) m_req[i] = 0;
      m_onq = 0; m_selq = 0; m_act = 0; m_ptr = 0;
    end else begin
      bit onr, onf, sr, sf, stop_all, trim;
      int first;
      bit setb[4], clrb[4], start[4];
      onr = pwr_on && !m_onq;
      onf = !pwr_on && m_onq;
      sr  = board_sel && !m_selq;
      sf  = !board_sel && m_selq;
      stop_all = onf || sf;
      trim = seq_en && (fault_off || sr);
      for (int i = 0; i < 4; i++) begin
        setb[i] = 0; clrb[i] = 0; start[i] = 0;
        if (onr && (!seq_en || i == 0)) begin setb[i] = 1; if (seq_en) start[i] = 1; end
        if (host_we) begin
          if (host_wdata[i] && !m_req[i] && !ramp_busy) begin setb[i] = 1; if (seq_en) start[i] = 1; end
          if (!host_wdata[i] && m_req[i]) clrb[i] = 1;
        end
        if (trim && i > 0) clrb[i] = 1;
        if (stop_all) clrb[i] = 1;
      end
      if (seq_en && m_act && ramp_done && m_ptr < 3 && !m_req[m_ptr+1]) setb[m_ptr+1] = 1;
      first = -1;
      for (int i = 3; i >= 0; i--) if (start[i]) first = i;
      if (stop_all || trim) m_act = 0;
      else if (first >= 0) begin m_act = 1; m_ptr = first; end
      else if (m_act && seq_en && ramp_done) begin
        if (m_ptr == 3 || m_req[m_ptr+1]) m_act = 0; else m_ptr = m_ptr + 1;
      end
      for (int i = 0; i < 4; i++) m_req[i] = (m_req[i] || setb[i]) && !clrb[i];
      m_onq = pwr_on; m_selq = board_sel;
    end
  end

  always @(negedge clk) begin
    #2;
    if (!done_flag) begin
      total++;
      if (status !== m_status()) begin
        bad++;
        $display("FAIL %s model compare: status=%h expected=%h", phase, status, m_status());
      end
    end
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] d);
    host_we = 1; host_wdata = d; tick(); host_we = 0;
  endtask

  task automatic rdone();
    ramp_done = 1; tick(); ramp_done = 0;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: got=hung expected=finish");
    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R1", status, 8'h00);
    rst_n = 1; board_sel = 1; tick(); tick();
    chk("R1", {4'h0, rail_en}, 8'h00);

    phase = "R2";
    pwr_on = 1; tick();
    chk("R2", {4'h0, rail_en}, 8'h0F);
    rail_armed = 4'b1010; tick();
    chk("R11", status, 8'hAF);

    phase = "R9";
    pwr_on = 0; tick();
    chk("R9", status, 8'h00);

    phase = "R3";
    seq_en = 1; rail_armed = 4'b1111;
    pwr_on = 1; tick();
    chk("R3", status, 8'h11);
    rdone(); chk("R3", status[3:0], 4'b0011);
    rdone(); chk("R3", status[3:0], 4'b0111);
    rdone(); chk("R3", status[3:0], 4'b1111);
    rdone(); chk("R4", status[3:0], 4'b1111);

    phase = "R5";
    wr(4'b0000); chk("R6", status[3:0], 4'b0000);
    wr(4'b0010); chk("R5", status[3:0], 4'b0010);
    rdone(); chk("R5", status[3:0], 4'b0110);
    rdone(); chk("R5", status[3:0], 4'b1110);
    rdone(); chk("R4", status[3:0], 4'b1110);

    phase = "R4";
    wr(4'b1111); chk("R4", status[3:0], 4'b1111);
    rdone(); chk("R4", status[3:0], 4'b1111);
    wr(4'b1011); rdone(); chk("R4", status[3:0], 4'b1011);

    phase = "R6";
    ramp_busy = 1;
    wr(4'b1111); chk("R6", status[3:0], 4'b1011);
    wr(4'b0001); chk("R6", status[3:0], 4'b0001);
    ramp_busy = 0;

    phase = "R7";
    wr(4'b1111); fault_off = 1; tick(); fault_off = 0;
    chk("R7", status[3:0], 4'b0001);
    rdone(); chk("R7", status[3:0], 4'b0001);
    seq_en = 0; wr(4'b1111); fault_off = 1; tick(); fault_off = 0;
    chk("R7", status[3:0], 4'b1111);

    phase = "R8";
    seq_en = 1; board_sel = 0; tick();
    chk("R9", status[3:0], 4'b0000);
    wr(4'b1111); board_sel = 1; tick();
    chk("R8", status[3:0], 4'b0001);

    phase = "R10";
    neg_off = 1; tick();
    chk("R10", {4'h0, rail_en}, 8'h09);
    wr(4'b0110); chk("R10", {4'h0, rail_en}, 8'h06);
    neg_off = 0;

    phase = "R11";
    wr(4'b0101); rail_armed = 4'b1111; tick();
    chk("R11", status, 8'h55);
    rail_armed = 4'b0100; tick();
    chk("R11", status, 8'h45);

    phase = "R12";
    wr(4'b0000); pwr_on = 0; tick(); pwr_on = 1; tick();
    chk("R12", status[3:0], 4'b0001);
    ramp_done = 1; host_we = 1; host_wdata = 4'b0101; tick();
    ramp_done = 0; host_we = 0;
    chk("R12", status[3:0], 4'b0111);
    host_we = 1; host_wdata = 4'b1111; fault_off = 1; tick();
    host_we = 0; fault_off = 0;
    chk("R12", status[3:0], 4'b0001);

    for (int n = 0; n < 3000; n++) begin
      pwr_on     = ($urandom % 16) != 0 ? pwr_on : ~pwr_on;
      board_sel  = ($urandom % 20) != 0 ? board_sel : ~board_sel;
      seq_en     = ($urandom % 40) != 0 ? seq_en : ~seq_en;
      neg_off    = ($urandom % 30) != 0 ? neg_off : ~neg_off;
      host_we    = ($urandom % 4) == 0;
      host_wdata = 4'($urandom);
      ramp_busy  = ($urandom % 3) == 0;
      ramp_done  = ($urandom % 4) == 0;
      fault_off  = ($urandom % 25) == 0;
      rail_armed = 4'($urandom);
      tick();
    end
    host_we = 0; ramp_done = 0; fault_off = 0;
    tick();

    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule